// File: doc/BRIEF.md
# Load/Store Queue Address Disambiguator

This block keeps memory operations of an in-order issue, out-of-order execute core in two circular queues, one for loads and one for stores. Operations are allocated in program order with a sequence tag. Their effective addresses arrive later, in any order. The block decides which load may be sent to memory and when the oldest store may write. It does this by comparing addresses across the two queues, so that memory ordering is kept without a single shared reservation station.

A load may be requested only when every older store still in the store queue has a known address that differs from its own. The store at the head of the store queue may write only when no older load that is still waiting could touch the same word. Stores leave the queue in program order when their write is granted. Granted loads are freed from the head of the load queue as the head entry completes.

Both memory request outputs are valid/ready streams. A request whose ready is low stays valid, and keeps its index and address unchanged, until it is accepted. Allocation is a plain valid/ready pair. It back-pressures only when the queue selected by the operation type is full.

Top module: `lsq_disambig`

## Requirements
- R1: Each queue holds DEPTH entries. `alloc_ready` is low exactly when the queue chosen by `alloc_is_store` is full. `alloc_idx` gives the slot the operation takes in that queue. Slots are handed out in ascending order modulo DEPTH, starting at 0 after reset.
- R2: After reset, neither request output is valid and `alloc_ready` is high for both operation types.
- R3: A load is not requested while any older store in the store queue has no address yet.
- R4: A load is not requested while an older store in the store queue has the same word address. Address bits [1:0] are ignored in this comparison. Older stores to other words do not hold a load back, and younger stores never do.
- R5: A load whose own address has not arrived is never requested.
- R6: Among loads that may go, the oldest in queue order is requested. An eligible younger load is requested past an older load that is held back.
- R7: Only the head (oldest) store can be requested, and only once its address is known. Stores are therefore written in program order.
- R8: The head store is held while an older, not yet granted load has an unknown address or the same word address. Loads that are younger, already granted, or at other words do not hold it.
- R9: While a request is valid and its ready is low, it stays valid with the same index and address in the next cycle.
- R10: Age is decided from sequence tags modulo 2^SEQ_W. Tag a is older than tag b when (a - b) mod 2^SEQ_W has its top bit set, so ordering holds across tag wrap-around.
- R11: When a store write is accepted, the store leaves the queue at that clock edge. A load that only it was holding back is requested from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one operation |
| alloc_is_store | input | 1 | 1 for a store, 0 for a load |
| alloc_tag | input | SEQ_W | Program-order sequence tag |
| alloc_ready | output | 1 | Target queue has a free slot |
| alloc_idx | output | IW | Slot taken in the target queue |
| addr_valid | input | 1 | Effective address delivery |
| addr_is_store | input | 1 | Address belongs to the store queue |
| addr_idx | input | IW | Slot receiving the address |
| addr_byte | input | AW | Effective byte address |
| ld_req_valid | output | 1 | A load may access memory |
| ld_req_ready | input | 1 | Memory accepts the load |
| ld_req_idx | output | IW | Load queue slot of the request |
| ld_req_addr | output | AW | Address of the requested load |
| st_req_valid | output | 1 | Head store may write |
| st_req_ready | input | 1 | Memory accepts the store write |
| st_req_addr | output | AW | Address of the head store |

## Verification
The assertions take for granted that allocation is attempted only with `alloc_ready` high, that each slot receives its address once while it is occupied, and that the tags of operations alive together span less than half the tag range. The stimulus allocates only through the ready handshake. It sends each address once, to a slot it has just been given. It keeps at most a few tags alive at a time, and it jumps across the wrap point only when the queues hold nothing older. Ready inputs are held low while the blocking conditions are observed, so that the hold rule is exercised.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  // a is older than b when (a - b) wraps negative in a w-bit space
  function automatic logic is_older(input logic [31:0] a, input logic [31:0] b, input int w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction
endpackage

// File: rtl/lsq_ring.sv
module lsq_ring #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic          full,
  output logic          empty
);
  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (head == tail) && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      full <= 1'b0;
    end else begin
      if (push) tail <= bump(tail);
      if (pop)  head <= bump(head);
      if (push && !pop)      full <= (bump(tail) == head);
      else if (pop && !push) full <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> (!full || pop)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R1
endmodule

// File: rtl/lsq_load_q.sv
module lsq_load_q import lsq_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 6,
  parameter int AW    = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [SEQ_W-1:0]            push_tag,
  input  logic                        addr_set,
  input  logic [IW-1:0]               addr_idx,
  input  logic [AW-1:0]               addr_val,
  input  logic [DEPTH-1:0]            st_vld,
  input  logic [DEPTH-1:0]            st_known,
  input  logic [DEPTH-1:0][SEQ_W-1:0] st_tag,
  input  logic [DEPTH-1:0][AW-1:0]    st_addr,
  input  logic                        req_ready,
  output logic                        req_valid,
  output logic [IW-1:0]               req_idx,
  output logic [AW-1:0]               req_addr,
  output logic [IW-1:0]               tail,
  output logic                        full,
  output logic [DEPTH-1:0]            pend,
  output logic [DEPTH-1:0]            known,
  output logic [DEPTH-1:0][SEQ_W-1:0] tag,
  output logic [DEPTH-1:0][AW-1:0]    addr
);
  logic [DEPTH-1:0] vld, iss, blk, elig;
  logic [IW-1:0]    head, pick;
  logic             found, empty, pop, lock_v;
  logic [IW-1:0]    lock_i;

  assign pop = vld[head] && iss[head];

  lsq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head), .tail(tail), .full(full), .empty(empty)
  );

  // RAW screen: every older store must be known and at another word
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      blk[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (st_vld[j] && is_older(32'(st_tag[j]), 32'(tag[i]), SEQ_W) &&
            (!st_known[j] || st_addr[j][AW-1:2] == addr[i][AW-1:2]))
          blk[i] = 1'b1;
      end
      elig[i] = vld[i] && known[i] && !iss[i] && !blk[i];
    end
  end

  // oldest eligible entry, walking from head
  always_comb begin
    found = 1'b0;
    pick  = head;
    for (int off = 0; off < DEPTH; off++) begin
      int idx;
      idx = int'(head) + off;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

  assign req_valid = lock_v || found;
  assign req_idx   = lock_v ? lock_i : pick;
  assign req_addr  = addr[req_idx];
  assign pend      = vld & ~iss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      iss    <= '0;
      known  <= '0;
      tag    <= '0;
      addr   <= '0;
      lock_v <= 1'b0;
      lock_i <= '0;
    end else begin
      lock_v <= req_valid && !req_ready;
      lock_i <= req_idx;
      if (req_valid && req_ready) iss[req_idx] <= 1'b1;
      if (pop) vld[head] <= 1'b0;
      if (push) begin
        vld[tail]   <= 1'b1;
        iss[tail]   <= 1'b0;
        known[tail] <= 1'b0;
        tag[tail]   <= push_tag;
      end
      if (addr_set) begin
        known[addr_idx] <= 1'b1;
        addr[addr_idx]  <= addr_val;
      end
    end
  end

  AST_LD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_idx) && $stable(req_addr))); // R9
  AST_LD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (vld[req_idx] && !iss[req_idx] && known[req_idx])); // R5
endmodule

// File: rtl/lsq_store_q.sv
module lsq_store_q import lsq_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 6,
  parameter int AW    = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [SEQ_W-1:0]            push_tag,
  input  logic                        addr_set,
  input  logic [IW-1:0]               addr_idx,
  input  logic [AW-1:0]               addr_val,
  input  logic [DEPTH-1:0]            ld_pend,
  input  logic [DEPTH-1:0]            ld_known,
  input  logic [DEPTH-1:0][SEQ_W-1:0] ld_tag,
  input  logic [DEPTH-1:0][AW-1:0]    ld_addr,
  input  logic                        req_ready,
  output logic                        req_valid,
  output logic [AW-1:0]               req_addr,
  output logic [IW-1:0]               tail,
  output logic                        full,
  output logic [DEPTH-1:0]            vld,
  output logic [DEPTH-1:0]            known,
  output logic [DEPTH-1:0][SEQ_W-1:0] tag,
  output logic [DEPTH-1:0][AW-1:0]    addr
);
  logic [IW-1:0] head;
  logic          empty, pop, war_blk;

  assign pop = req_valid && req_ready;

  lsq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head), .tail(tail), .full(full), .empty(empty)
  );

  // WAR screen against older loads still waiting
  always_comb begin
    war_blk = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (ld_pend[k] && is_older(32'(ld_tag[k]), 32'(tag[head]), SEQ_W) &&
          (!ld_known[k] || ld_addr[k][AW-1:2] == addr[head][AW-1:2]))
        war_blk = 1'b1;
    end
  end

  assign req_valid = vld[head] && known[head] && !war_blk;
  assign req_addr  = addr[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      known <= '0;
      tag   <= '0;
      addr  <= '0;
    end else begin
      if (pop) vld[head] <= 1'b0;
      if (push) begin
        vld[tail]   <= 1'b1;
        known[tail] <= 1'b0;
        tag[tail]   <= push_tag;
      end
      if (addr_set) begin
        known[addr_idx] <= 1'b1;
        addr[addr_idx]  <= addr_val;
      end
    end
  end

  AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R9
  AST_ST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !empty); // R7
endmodule

// File: rtl/lsq_disambig.sv
module lsq_disambig #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 6,
  parameter int AW    = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic             alloc_is_store,
  input  logic [SEQ_W-1:0] alloc_tag,
  output logic             alloc_ready,
  output logic [IW-1:0]    alloc_idx,
  input  logic             addr_valid,
  input  logic             addr_is_store,
  input  logic [IW-1:0]    addr_idx,
  input  logic [AW-1:0]    addr_byte,
  output logic             ld_req_valid,
  input  logic             ld_req_ready,
  output logic [IW-1:0]    ld_req_idx,
  output logic [AW-1:0]    ld_req_addr,
  output logic             st_req_valid,
  input  logic             st_req_ready,
  output logic [AW-1:0]    st_req_addr
);
  logic [IW-1:0]               lq_tail, sq_tail;
  logic                        lq_full, sq_full;
  logic [DEPTH-1:0]            lq_pend, lq_known, sq_vld, sq_known;
  logic [DEPTH-1:0][SEQ_W-1:0] lq_tag, sq_tag;
  logic [DEPTH-1:0][AW-1:0]    lq_addr, sq_addr;
  logic                        lq_push, sq_push;

  assign alloc_ready = alloc_is_store ? !sq_full : !lq_full;
  assign alloc_idx   = alloc_is_store ? sq_tail : lq_tail;
  assign lq_push     = alloc_valid && alloc_ready && !alloc_is_store;
  assign sq_push     = alloc_valid && alloc_ready && alloc_is_store;

  lsq_load_q #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AW(AW)) u_lq (
    .clk(clk), .rst_n(rst_n),
    .push(lq_push), .push_tag(alloc_tag),
    .addr_set(addr_valid && !addr_is_store), .addr_idx(addr_idx), .addr_val(addr_byte),
    .st_vld(sq_vld), .st_known(sq_known), .st_tag(sq_tag), .st_addr(sq_addr),
    .req_ready(ld_req_ready), .req_valid(ld_req_valid), .req_idx(ld_req_idx),
    .req_addr(ld_req_addr), .tail(lq_tail), .full(lq_full),
    .pend(lq_pend), .known(lq_known), .tag(lq_tag), .addr(lq_addr)
  );

  lsq_store_q #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AW(AW)) u_sq (
    .clk(clk), .rst_n(rst_n),
    .push(sq_push), .push_tag(alloc_tag),
    .addr_set(addr_valid && addr_is_store), .addr_idx(addr_idx), .addr_val(addr_byte),
    .ld_pend(lq_pend), .ld_known(lq_known), .ld_tag(lq_tag), .ld_addr(lq_addr),
    .req_ready(st_req_ready), .req_valid(st_req_valid), .req_addr(st_req_addr),
    .tail(sq_tail), .full(sq_full),
    .vld(sq_vld), .known(sq_known), .tag(sq_tag), .addr(sq_addr)
  );

  AST_ALLOC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> $stable(alloc_is_store ? sq_tail : lq_tail)); // R1
endmodule

// File: tb/tb_lsq_disambig.sv
module tb_lsq_disambig;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0, alloc_is_store = 1'b0;
  logic [5:0]  alloc_tag = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_idx;
  logic        addr_valid = 1'b0, addr_is_store = 1'b0;
  logic [2:0]  addr_idx = '0;
  logic [31:0] addr_byte = '0;
  logic        ld_req_valid, st_req_valid;
  logic        ld_req_ready = 1'b0, st_req_ready = 1'b0;
  logic [2:0]  ld_req_idx;
  logic [31:0] ld_req_addr, st_req_addr;

  int vectors = 0;
  int misses  = 0;
  int exp_ld_idx[$];
  logic [31:0] exp_ld_addr[$];
  logic [31:0] exp_st_addr[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsq_disambig dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store), .alloc_tag(alloc_tag),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .addr_valid(addr_valid), .addr_is_store(addr_is_store), .addr_idx(addr_idx),
    .addr_byte(addr_byte),
    .ld_req_valid(ld_req_valid), .ld_req_ready(ld_req_ready), .ld_req_idx(ld_req_idx),
    .ld_req_addr(ld_req_addr),
    .st_req_valid(st_req_valid), .st_req_ready(st_req_ready), .st_req_addr(st_req_addr)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string rq);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic alloc(input logic st, input logic [5:0] tg, input logic [2:0] exp_idx);
    alloc_valid = 1'b1; alloc_is_store = st; alloc_tag = tg;
    #1;
    chk(32'(alloc_ready), 1, "R1 ready");
    chk(32'(alloc_idx), 32'(exp_idx), "R1 slot");
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic give_addr(input logic st, input logic [2:0] idx, input logic [31:0] a);
    addr_valid = 1'b1; addr_is_store = st; addr_idx = idx; addr_byte = a;
    @(posedge clk); #1;
    addr_valid = 1'b0;
  endtask

  task automatic expect_ld(input int idx, input logic [31:0] a);
    exp_ld_idx.push_back(idx);
    exp_ld_addr.push_back(a);
  endtask

  task automatic expect_st(input logic [31:0] a);
    exp_st_addr.push_back(a);
  endtask

  task automatic drain(input string rq);
    ld_req_ready = 1'b1; st_req_ready = 1'b1;
    for (int n = 0; n < 60 && (exp_ld_idx.size() != 0 || exp_st_addr.size() != 0); n++) step();
    step(); step();
    chk(32'(exp_ld_idx.size() + exp_st_addr.size()), 0, rq);
    ld_req_ready = 1'b0; st_req_ready = 1'b0;
  endtask

  // monitor: handshakes complete at the next rising edge
  always @(negedge clk) begin
    if (rst_n && ld_req_valid && ld_req_ready) begin
      if (exp_ld_idx.size() == 0) begin
        vectors++; misses++;
        $display("FAIL R6 load: unexpected idx %0d addr %0h expected none", ld_req_idx, ld_req_addr);
      end else begin
        chk(32'(ld_req_idx), 32'(exp_ld_idx.pop_front()), "R6 load idx");
        chk(ld_req_addr, exp_ld_addr.pop_front(), "R6 load addr");
      end
    end
    if (rst_n && st_req_valid && st_req_ready) begin
      if (exp_st_addr.size() == 0) begin
        vectors++; misses++;
        $display("FAIL R7 store: unexpected addr %0h expected none", st_req_addr);
      end else begin
        chk(st_req_addr, exp_st_addr.pop_front(), "R7 store addr");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(32'(ld_req_valid), 0, "R2 ld idle");
    chk(32'(st_req_valid), 0, "R2 st idle");
    chk(32'(alloc_ready), 1, "R2 load ready");
    alloc_is_store = 1'b1; #1;
    chk(32'(alloc_ready), 1, "R2 store ready");
    step();

    // older store, unknown then distinct address
    alloc(1'b1, 6'd0, 3'd0);
    alloc(1'b0, 6'd1, 3'd0);
    give_addr(1'b0, 3'd0, 32'h10);
    @(negedge clk);
    chk(32'(ld_req_valid), 0, "R3 unknown older store");
    step();
    give_addr(1'b1, 3'd0, 32'h20);
    @(negedge clk);
    chk(32'(ld_req_valid), 1, "R4 distinct word");
    chk(32'(st_req_valid), 1, "R8 younger load");
    step();
    expect_ld(0, 32'h10); expect_st(32'h20);
    drain("R4 drain");

    // same word, byte offset differs
    alloc(1'b1, 6'd2, 3'd1);
    alloc(1'b0, 6'd3, 3'd1);
    give_addr(1'b1, 3'd1, 32'h30);
    give_addr(1'b0, 3'd1, 32'h32);
    @(negedge clk);
    chk(32'(ld_req_valid), 0, "R4 same word");
    chk(32'(st_req_valid), 1, "R7 head store");
    step();
    expect_st(32'h30);
    st_req_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(32'(ld_req_valid), 1, "R11 release");
    step();
    expect_ld(1, 32'h32);
    drain("R11 drain");

    // WAR: older load blocks store
    alloc(1'b0, 6'd4, 3'd2);
    alloc(1'b1, 6'd5, 3'd2);
    give_addr(1'b1, 3'd2, 32'h40);
    @(negedge clk);
    chk(32'(st_req_valid), 0, "R8 older load unknown");
    chk(32'(ld_req_valid), 0, "R5 load no address");
    step();
    give_addr(1'b0, 3'd2, 32'h40);
    @(negedge clk);
    chk(32'(st_req_valid), 0, "R8 older load match");
    chk(32'(ld_req_valid), 1, "R4 younger store");
    repeat (3) @(negedge clk);
    chk(32'(ld_req_valid), 1, "R9 held valid");
    chk(32'(ld_req_idx), 2, "R9 held idx");
    chk(ld_req_addr, 32'h40, "R9 held addr");
    step();
    expect_ld(2, 32'h40);
    ld_req_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(32'(st_req_valid), 1, "R8 load granted");
    step();
    expect_st(32'h40);
    drain("R8 drain");

    // younger load bypasses older load without address
    alloc(1'b0, 6'd6, 3'd3);
    alloc(1'b1, 6'd7, 3'd3);
    alloc(1'b0, 6'd8, 3'd4);
    give_addr(1'b0, 3'd4, 32'h50);
    give_addr(1'b1, 3'd3, 32'h60);
    @(negedge clk);
    chk(32'(ld_req_valid), 1, "R6 bypass valid");
    chk(32'(ld_req_idx), 4, "R6 bypass idx");
    chk(32'(st_req_valid), 0, "R8 older unknown load");
    step();
    give_addr(1'b0, 3'd3, 32'h70);
    @(negedge clk);
    chk(32'(ld_req_idx), 4, "R9 locked idx");
    chk(32'(st_req_valid), 1, "R8 other word");
    step();
    expect_ld(4, 32'h50); expect_ld(3, 32'h70); expect_st(32'h60);
    drain("R6 drain");

    // two loads released together: oldest first
    alloc(1'b1, 6'd9, 3'd4);
    alloc(1'b0, 6'd10, 3'd5);
    alloc(1'b0, 6'd11, 3'd6);
    give_addr(1'b0, 3'd6, 32'h90);
    give_addr(1'b0, 3'd5, 32'hA0);
    @(negedge clk);
    chk(32'(ld_req_valid), 0, "R3 both held");
    step();
    give_addr(1'b1, 3'd4, 32'hB0);
    @(negedge clk);
    chk(32'(ld_req_idx), 5, "R6 oldest first");
    step();
    expect_ld(5, 32'hA0); expect_ld(6, 32'h90); expect_st(32'hB0);
    drain("R6 order drain");

    // fill store queue, slots wrap
    for (int k = 0; k < 8; k++) alloc(1'b1, 6'(12 + k), 3'((5 + k) % 8));
    alloc_is_store = 1'b1;
    @(negedge clk);
    chk(32'(alloc_ready), 0, "R1 store full");
    alloc_is_store = 1'b0; #1;
    chk(32'(alloc_ready), 1, "R1 load room");
    step();
    for (int k = 0; k < 8; k++) begin
      give_addr(1'b1, 3'((5 + k) % 8), 32'h100 + 32'(4 * k));
      expect_st(32'h100 + 32'(4 * k));
    end
    drain("R7 in-order drain");

    // tag wrap: 63 is older than 1
    alloc(1'b1, 6'd63, 3'd5);
    alloc(1'b0, 6'd1, 3'd7);
    give_addr(1'b0, 3'd7, 32'hC0);
    @(negedge clk);
    chk(32'(ld_req_valid), 0, "R10 wrap older store");
    step();
    give_addr(1'b1, 3'd5, 32'hC4);
    @(negedge clk);
    chk(32'(ld_req_valid), 1, "R10 wrap released");
    step();
    expect_ld(7, 32'hC0); expect_st(32'hC4);
    drain("R10 drain");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule